// File: doc/BRIEF.md
# Table-Driven Pixel Scatter Sequencer

This block takes a raster stream of camera pixels from a parallel input, one pixel per cycle when a valid strobe is high, and writes each pixel to processor memory at an address looked up per pixel position in a loadable table. Software fills the table so that the pixels land grouped the way later gradient computation wants them. It does not use a linear address counter. A frame-sync input is the timing master: it restarts the table walk at the first pixel of each frame.

Each table entry also carries a small increment. A nonzero increment means that, once this pixel is stored, that many more slopes have their data complete. The block keeps a running ready count and pulses an update strobe, so that slope arithmetic downstream can work in a pipeline alongside the readout. The block flags pixels beyond the table's end and signals the last pixel of a frame of configured size. The table is loaded while sequencing is disabled. The default table depth is kept small for elaboration. A full 80x80 sensor needs `TBL_DEPTH` = 6400.

Top module: `pix_seq_top`

## Requirements
- R1: Table writes (`tbl_we_i`) store `tbl_dst_i` and `tbl_inc_i` at entry `tbl_idx_i` only while `en_i` is low. A table write while `en_i` is high leaves the table unchanged.
- R2: A pixel is accepted when `en_i` and `pix_valid_i` are high and its frame position is below `TBL_DEPTH`. Each accepted pixel produces, one cycle later, `mem_we_o`=1, `mem_addr_o` = the destination of the entry at that position, and `mem_data_o` = the pixel.
- R3: The frame position advances by one per accepted pixel. Cycles without `pix_valid_i` do not advance it and produce no write.
- R4: When `fsync_i` is high, the position and the ready count restart from 0. A pixel on the same cycle uses entry 0.
- R5: When an accepted pixel's entry increment is nonzero, `ready_cnt_o` grows by that increment and `ready_upd_o` pulses in the same cycle as the write. A zero increment leaves the count unchanged and gives no pulse.
- R6: A valid pixel at position `TBL_DEPTH` or beyond is dropped with no write. It sets `ovf_o`, which stays high until a frame sync or a disable.
- R7: `eof_o` pulses together with the write of the pixel whose 1-based position equals `frame_size_i`.
- R8: While `en_i` is low, pixels are ignored. The position, `ready_cnt_o` and `ovf_o` are cleared one cycle later.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencing enable |
| frame_size_i | input | CNT_W | Pixels per frame |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Table entry index |
| tbl_dst_i | input | ADDR_W | Destination address for entry |
| tbl_inc_i | input | INC_W | Slopes-ready increment for entry |
| fsync_i | input | 1 | Frame sync, start of frame |
| pix_valid_i | input | 1 | Pixel valid strobe |
| pix_data_i | input | PIX_W | Pixel value |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | PIX_W | Memory write data |
| ready_cnt_o | output | RDY_W | Cumulative slopes-ready count |
| ready_upd_o | output | 1 | Ready count update strobe |
| eof_o | output | 1 | End-of-frame pulse |
| ovf_o | output | 1 | Table overrun flag |

## Verification
The first stimulus is random tables with random valid gaps and frame syncs at random points. It checks that the address follows the table position rather than the cycle count, and that zero and nonzero increments are handled differently. Directed frames longer than the table separate the drop-and-flag path from normal writes. A sync that coincides with a pixel shows whether entry 0 is used at once. Table writes attempted while enabled, followed by a frame, show from the addresses that come out whether the write gate works. Frames with different configured sizes place the end pulse at varying positions.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned INC_W  = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [INC_W-1:0]  inc;
  } tbl_entry_t;
endpackage

// File: rtl/pix_seq_lut.sv
module pix_seq_lut
  import pix_seq_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH),
  localparam int unsigned CNT_W = $clog2(TBL_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  tbl_entry_t       wdata_i,
  input  logic [CNT_W-1:0] ridx_i,
  output tbl_entry_t       rdata_o
);
  tbl_entry_t mem_q [TBL_DEPTH];

  // writes gated by disable so the walk never sees a changing table
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && !en_i && widx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ridx_i < CNT_W'(TBL_DEPTH)) rdata_o = mem_q[ridx_i[IDX_W-1:0]];
  end
endmodule

// File: rtl/pix_seq_ctrl.sv
module pix_seq_ctrl #(
  parameter int unsigned TBL_DEPTH = 256,
  localparam int unsigned CNT_W = $clog2(TBL_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fsync_i,
  input  logic             pix_valid_i,
  input  logic [CNT_W-1:0] frame_size_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             accept_o,
  output logic             last_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] pos_q;
  logic             drop;

  assign pos_o    = fsync_i ? '0 : pos_q;
  assign accept_o = en_i && pix_valid_i && (pos_o < CNT_W'(TBL_DEPTH));
  assign drop     = en_i && pix_valid_i && !accept_o;
  assign last_o   = accept_o && (pos_o + CNT_W'(1) == frame_size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      ovf_o <= 1'b0;
    end else if (!en_i) begin
      pos_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      pos_q <= accept_o ? pos_o + CNT_W'(1) : pos_o;
      ovf_o <= drop || (ovf_o && !fsync_i);
    end
  end
endmodule

// File: rtl/pix_seq_out.sv
module pix_seq_out
  import pix_seq_pkg::*;
#(
  parameter int unsigned PIX_W = 16,
  parameter int unsigned RDY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fsync_i,
  input  logic              accept_i,
  input  logic              last_i,
  input  tbl_entry_t        ent_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_data_o,
  output logic [RDY_W-1:0]  ready_cnt_o,
  output logic              ready_upd_o,
  output logic              eof_o
);
  logic [RDY_W-1:0] base;
  logic             bump;

  assign base = fsync_i ? '0 : ready_cnt_o;
  assign bump = accept_i && (ent_i.inc != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      ready_cnt_o <= '0;
      ready_upd_o <= 1'b0;
      eof_o       <= 1'b0;
    end else begin
      mem_we_o    <= accept_i;
      ready_upd_o <= bump;
      eof_o       <= last_i;
      if (accept_i) begin
        mem_addr_o <= ent_i.dst;
        mem_data_o <= pix_i;
      end
      if (!en_i)     ready_cnt_o <= '0;
      else if (bump) ready_cnt_o <= base + RDY_W'(ent_i.inc);
      else           ready_cnt_o <= base;
    end
  end
endmodule

// File: rtl/pix_seq_top.sv
module pix_seq_top
  import pix_seq_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 256,
  parameter int unsigned PIX_W     = 16,
  parameter int unsigned RDY_W     = 16,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH),
  localparam int unsigned CNT_W = $clog2(TBL_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  frame_size_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [ADDR_W-1:0] tbl_dst_i,
  input  logic [INC_W-1:0]  tbl_inc_i,
  input  logic              fsync_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_data_o,
  output logic [RDY_W-1:0]  ready_cnt_o,
  output logic              ready_upd_o,
  output logic              eof_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] pos;
  logic             accept, last;
  tbl_entry_t       wr_ent, rd_ent;

  assign wr_ent.dst = tbl_dst_i;
  assign wr_ent.inc = tbl_inc_i;

  pix_seq_lut #(.TBL_DEPTH(TBL_DEPTH)) u_lut (
    .clk_i, .rst_ni, .en_i,
    .we_i(tbl_we_i), .widx_i(tbl_idx_i), .wdata_i(wr_ent),
    .ridx_i(pos), .rdata_o(rd_ent)
  );

  pix_seq_ctrl #(.TBL_DEPTH(TBL_DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .fsync_i, .pix_valid_i, .frame_size_i,
    .pos_o(pos), .accept_o(accept), .last_o(last), .ovf_o
  );

  pix_seq_out #(.PIX_W(PIX_W), .RDY_W(RDY_W)) u_out (
    .clk_i, .rst_ni, .en_i, .fsync_i,
    .accept_i(accept), .last_i(last), .ent_i(rd_ent), .pix_i(pix_data_i),
    .mem_we_o, .mem_addr_o, .mem_data_o, .ready_cnt_o, .ready_upd_o, .eof_o
  );
endmodule

// File: rtl/pix_seq_chk.sv
module pix_seq_chk #(
  parameter int unsigned RDY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             fsync_i,
  input logic             pix_valid_i,
  input logic             mem_we_o,
  input logic [RDY_W-1:0] ready_cnt_o,
  input logic             ready_upd_o,
  input logic             eof_o,
  input logic             ovf_o
);
  assert_write_needs_pixel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && pix_valid_i) |=> !mem_we_o);

  assert_upd_with_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_upd_o |-> mem_we_o);

  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fsync_i && !pix_valid_i) |=> $stable(ready_cnt_o));

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && en_i && !fsync_i) |=> ovf_o);

  assert_ovf_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(en_i && pix_valid_i)) |=> !ovf_o);

  assert_eof_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> mem_we_o);

  assert_disable_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mem_we_o && !ovf_o && ready_cnt_o == '0 && !ready_upd_o));
endmodule

bind pix_seq_top pix_seq_chk #(.RDY_W(RDY_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .fsync_i, .pix_valid_i,
  .mem_we_o, .ready_cnt_o, .ready_upd_o, .eof_o, .ovf_o
);

// File: tb/sim_pix_seq_top.sv
`timescale 1ns/1ps
module sim_pix_seq_top;
  localparam int D = 32;
  localparam int CW = $clog2(D + 1);
  localparam int IW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic en = 0, tbl_we = 0, fsync = 0, pv = 0;
  logic [CW-1:0] fsize = CW'(D);
  logic [IW-1:0] tidx = '0;
  logic [15:0] tdst = '0, pdata = '0;
  logic [3:0]  tinc = '0;
  logic mem_we, upd, eof, ovf;
  logic [15:0] maddr, mdata, rcnt;

  int checks = 0, fails = 0;
  logic [15:0] m_dst [D];
  logic [3:0]  m_inc [D];
  int m_pos = 0, m_rdy = 0;
  bit m_ovf = 0;

  always #4 clk = ~clk;

  pix_seq_top #(.TBL_DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frame_size_i(fsize),
    .tbl_we_i(tbl_we), .tbl_idx_i(tidx), .tbl_dst_i(tdst), .tbl_inc_i(tinc),
    .fsync_i(fsync), .pix_valid_i(pv), .pix_data_i(pdata),
    .mem_we_o(mem_we), .mem_addr_o(maddr), .mem_data_o(mdata),
    .ready_cnt_o(rcnt), .ready_upd_o(upd), .eof_o(eof), .ovf_o(ovf)
  );

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog R9 act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // table write: model follows only when disabled (R1)
  task automatic twrite(int i, int dst, int inc);
    tidx = IW'(i); tdst = 16'(dst); tinc = 4'(inc); tbl_we = 1;
    @(posedge clk); @(negedge clk);
    tbl_we = 0;
    if (!en) begin m_dst[i] = 16'(dst); m_inc[i] = 4'(inc); end
  endtask

  // one cycle with full reference model
  task automatic cyc(bit fs, bit v, int d);
    bit e_we, e_upd, e_eof;
    int e_addr, p;
    fsync = fs; pv = v; pdata = 16'(d);
    e_we = 0; e_upd = 0; e_eof = 0; e_addr = 0;
    if (!en) begin
      m_pos = 0; m_rdy = 0; m_ovf = 0;
    end else begin
      if (fs) begin m_pos = 0; m_rdy = 0; m_ovf = 0; end
      if (v) begin
        if (m_pos < D) begin
          p = m_pos;
          e_we = 1; e_addr = m_dst[p];
          if (m_inc[p] != 0) begin e_upd = 1; m_rdy = (m_rdy + m_inc[p]) & 16'hffff; end
          e_eof = (p + 1 == fsize);
          m_pos++;
        end else m_ovf = 1;
      end
    end
    @(posedge clk); @(negedge clk);
    fsync = 0; pv = 0;
    chk("R2 mem_we", mem_we, e_we);
    if (e_we) begin
      chk("R2 addr", maddr, e_addr);
      chk("R2 data", mdata, d & 16'hffff);
    end
    chk("R5 upd", upd, e_upd);
    chk("R5 cnt", rcnt, m_rdy);
    chk("R7 eof", eof, e_eof);
    chk("R6 ovf", ovf, m_ovf);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < D; i++) begin m_dst[i] = 0; m_inc[i] = 0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 we", mem_we, 0); chk("R9 cnt", rcnt, 0); chk("R9 ovf", ovf, 0);
    chk("R9 eof", eof, 0); chk("R9 upd", upd, 0);
    rst_n = 1; @(negedge clk);

    for (int i = 0; i < D; i++) twrite(i, 16'h1000 + ((i * 7) % D), (i % 3 == 2) ? 2 : 0);
    en = 1; @(negedge clk);
    // R1: writes while enabled ignored, seen through addresses of next frame
    twrite(0, 16'hdead, 9); twrite(1, 16'hbeef, 9);
    // R3 R4: frame with gaps, sync with pixel
    cyc(1, 1, 11);
    for (int i = 0; i < 12; i++) cyc(0, (i % 3) != 1, 100 + i);
    // R4 mid-frame restart
    cyc(1, 1, 55); cyc(0, 1, 56);
    // R6 overrun: run past table end
    fsize = CW'(D);
    cyc(1, 0, 0);
    for (int i = 0; i < D + 4; i++) cyc(0, 1, 200 + i);
    cyc(0, 0, 0);
    cyc(1, 1, 7); // sync clears ovf
    // R8 disable clears and ignores
    en = 0; cyc(0, 1, 9); cyc(0, 1, 10);
    // reload random table while disabled
    for (int i = 0; i < D; i++) twrite(i, $urandom & 16'hffff, ($urandom % 2) ? ($urandom & 15) : 0);
    en = 1;
    // random frames, random sizes (R7 at varying positions)
    for (int f = 0; f < 40; f++) begin
      fsize = CW'(1 + ($urandom % D));
      cyc(1, $urandom % 2, $urandom);
      for (int k = 0; k < 10 + ($urandom % (D + 8)); k++)
        cyc(0, ($urandom % 4) != 0, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule